// File: doc/BRIEF.md
# Four-Level Address Translation Walker

This block turns a 48-bit virtual address into a physical page number. It does this by reading page-table entries through a single memory port, one request at a time. A full walk reads four entries in a fixed order: the top level, the second level, the directory level and the table level. Each entry supplies the frame of the next table. At every level the block checks the present, writable and user flags against the access kind, and it folds the writable and user rights of all levels into one merged permission pair.

The block keeps a small fully associative cache of second-level results, keyed by virtual address bits 47:30. A hit in this cache supplies the directory-table frame and the rights merged over the first two levels. The walk then starts at the directory level and needs only two reads. When a walk succeeds, the block writes the table entry back with its accessed flag set, and only then reports the translation, which is ready to be loaded into a TLB.

The walker accepts a request when `req_ready` is high. It pulses `done` for one cycle with the result. The memory port keeps a request valid, with a stable address, until the memory answers with `mem_rsp_valid`.

Top module: `xlate_walker`

## Requirements
- R1: After reset, `req_ready` is 1, and `done` and `mem_req_valid` are 0.
- R2: Without a cache hit, the first read goes to the top-level entry. The address of an entry is frame*4096 + index*8, and the level indices are vaddr[47:39] (top), [38:30] (second), [29:21] (directory) and [20:12] (table). Reads follow the order top, second, directory, table, and the request address stays stable until the response.
- R3: Entry format: bit 0 present, bit 1 writable, bit 2 user, bit 5 accessed, bits 51:12 frame. A non-present entry at any level ends the walk at once with `res_fault` = 1 (not present), and no further memory access follows.
- R4: A write access needs the writable bit and a user access needs the user bit at every level read. A failed check ends the walk at once with `res_fault` = 2 (permission).
- R5: On success `res_fault` = 0, and `res_pfn` is the frame of the table entry. `res_perm` is {AND of writable bits, AND of user bits} over all levels, and `res_paddr` is {res_pfn, vaddr[11:0]}.
- R6: On success, exactly one memory write goes out before `done`, to the table entry's address, with data equal to that entry with bit 5 set. A faulting walk writes nothing.
- R7: Once a walk gets past the second level, a later request with the same vaddr[47:30] hits the cache. It starts reading at the directory entry and needs two reads for a full translation.
- R8: On a cache hit, the access check uses the cached merged rights. A failed check there returns fault 2 with no memory access at all.
- R9: The cache holds 4 entries that are replaced in round-robin order. A region displaced by later insertions walks from the top level again.
- R10: A walk that passes the second level but faults at the directory or table level still fills the cache. A walk that faults at the top or second level does not.
- R11: `done` lasts exactly one cycle, and `req_ready` is low for the whole walk, from acceptance until `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_pfn | input | 40 | Frame of the top-level table |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vaddr | input | 48 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| mem_req_valid | output | 1 | Memory access pending |
| mem_req_write | output | 1 | Pending access is a write |
| mem_req_addr | output | 52 | Physical byte address of the entry |
| mem_req_wdata | output | 64 | Write data (entry with accessed bit) |
| mem_rsp_valid | input | 1 | Memory completes the pending access |
| mem_rsp_rdata | input | 64 | Read data for a read access |
| done | output | 1 | One-cycle result strobe |
| res_fault | output | 2 | 0 none, 1 not present, 2 permission |
| res_pfn | output | 40 | Translated physical frame |
| res_paddr | output | 52 | Translated physical byte address |
| res_perm | output | 2 | Merged rights {writable, user} |

## Verification
Two things can happen in the same cycle. The second-level response both fills the directory cache and gets its own flag check, and a later check in that walk may then fault. The bench provokes this with a region whose directory entry is absent: the first walk faults after three reads, and the repeat has to start from the cache with a single read. The opposite case is a permission fault at the second level, which must leave the cache unchanged; the repeat is judged by its read count and by the address of its first read. Round-robin eviction comes into play when new insertions displace a region, and that region's next walk is judged by whether it starts at the top level again.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
    localparam int IDX_W       = 9;
    localparam int OFF_W       = 12;
    localparam int ENTRY_W     = 64;
    localparam int BIT_PRESENT = 0;
    localparam int BIT_WRITE   = 1;
    localparam int BIT_USER    = 2;
    localparam int BIT_ACCESS  = 5;
    localparam int FRAME_LSB   = 12;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_ABSENT = 2'd1,
        FLT_PERM   = 2'd2
    } fault_e;
endpackage

// File: rtl/xlate_permchk.sv
module xlate_permchk
    import xlate_pkg::*;
#(
    parameter int PFN_W = 40
) (
    input  logic [ENTRY_W-1:0] entry,
    input  logic               acc_write,
    input  logic               acc_user,
    output fault_e             fault,
    output logic [1:0]         rights,
    output logic [PFN_W-1:0]   frame
);
    always_comb begin
        rights = {entry[BIT_WRITE], entry[BIT_USER]};
        frame  = entry[FRAME_LSB +: PFN_W];
        if (!entry[BIT_PRESENT]) begin
            fault = FLT_ABSENT;
        end else if ((acc_write && !entry[BIT_WRITE]) || (acc_user && !entry[BIT_USER])) begin
            fault = FLT_PERM;
        end else begin
            fault = FLT_NONE;
        end
    end
endmodule

// File: rtl/xlate_dircache.sv
module xlate_dircache #(
    parameter int DEPTH = 4,
    parameter int TAG_W = 18,
    parameter int PFN_W = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    output logic [PFN_W-1:0] lk_frame,
    output logic [1:0]       lk_rights,
    input  logic             ins_en,
    input  logic [TAG_W-1:0] ins_tag,
    input  logic [PFN_W-1:0] ins_frame,
    input  logic [1:0]       ins_rights
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0] vld;
    logic [TAG_W-1:0] tag_q    [DEPTH];
    logic [PFN_W-1:0] frame_q  [DEPTH];
    logic [1:0]       rights_q [DEPTH];
    logic [DEPTH-1:0] match;
    logic [PTR_W-1:0] victim;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        assign match[g] = vld[g] && (tag_q[g] == lk_tag);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld[g]      <= 1'b0;
                tag_q[g]    <= '0;
                frame_q[g]  <= '0;
                rights_q[g] <= '0;
            end else if (ins_en && (victim == PTR_W'(g))) begin
                vld[g]      <= 1'b1;
                tag_q[g]    <= ins_tag;
                frame_q[g]  <= ins_frame;
                rights_q[g] <= ins_rights;
            end
        end
    end

    always_comb begin
        lk_hit    = |match;
        lk_frame  = '0;
        lk_rights = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (match[i]) begin
                lk_frame  = frame_q[i];
                lk_rights = rights_q[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            victim <= '0;
        end else if (ins_en) begin
            victim <= (victim == PTR_W'(DEPTH - 1)) ? '0 : victim + 1'b1;
        end
    end
endmodule

// File: rtl/xlate_walker.sv
module xlate_walker
    import xlate_pkg::*;
#(
    parameter int VA_W      = 48,
    parameter int PFN_W     = 40,
    parameter int PDC_DEPTH = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [PFN_W-1:0]         root_pfn,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [VA_W-1:0]          req_vaddr,
    input  logic                     req_write,
    input  logic                     req_user,
    output logic                     mem_req_valid,
    output logic                     mem_req_write,
    output logic [PFN_W+OFF_W-1:0]   mem_req_addr,
    output logic [ENTRY_W-1:0]       mem_req_wdata,
    input  logic                     mem_rsp_valid,
    input  logic [ENTRY_W-1:0]       mem_rsp_rdata,
    output logic                     done,
    output logic [1:0]               res_fault,
    output logic [PFN_W-1:0]         res_pfn,
    output logic [PFN_W+OFF_W-1:0]   res_paddr,
    output logic [1:0]               res_perm
);
    localparam int PA_W    = PFN_W + OFF_W;
    localparam int TAG_LSB = OFF_W + 2 * IDX_W;
    localparam int TAG_W   = VA_W - TAG_LSB;
    localparam int ESZ_W   = $clog2(ENTRY_W / 8);

    typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_MARK, ST_RESP} state_e;

    state_e              state, nxt;
    logic [1:0]          lvl;
    logic [VA_W-1:0]     va_q;
    logic                wr_q, us_q;
    logic [PFN_W-1:0]    frame_q;
    logic [1:0]          rights_q;
    logic [ENTRY_W-1:0]  leaf_q;
    logic [PA_W-1:0]     leaf_addr_q;
    logic [IDX_W-1:0]    idx;
    logic [PA_W-1:0]     entry_addr;

    logic                pdc_hit;
    logic [PFN_W-1:0]    pdc_frame;
    logic [1:0]          pdc_rights;
    logic                pdc_ins;
    logic                pdc_deny;

    fault_e              chk_fault;
    logic [1:0]          chk_rights;
    logic [PFN_W-1:0]    chk_frame;

    logic                accept;
    logic                rd_done;

    assign idx        = va_q[OFF_W + 32'(lvl) * IDX_W +: IDX_W];
    assign entry_addr = {frame_q, {OFF_W{1'b0}}} + PA_W'({idx, {ESZ_W{1'b0}}});
    assign accept     = (state == ST_IDLE) && req_valid;
    assign rd_done    = (state == ST_FETCH) && mem_rsp_valid;
    assign pdc_deny   = (req_write && !pdc_rights[1]) || (req_user && !pdc_rights[0]);
    assign pdc_ins    = rd_done && (lvl == 2'd2) && (chk_fault == FLT_NONE);

    xlate_dircache #(.DEPTH(PDC_DEPTH), .TAG_W(TAG_W), .PFN_W(PFN_W)) u_pdc (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_tag     (req_vaddr[VA_W-1:TAG_LSB]),
        .lk_hit     (pdc_hit),
        .lk_frame   (pdc_frame),
        .lk_rights  (pdc_rights),
        .ins_en     (pdc_ins),
        .ins_tag    (va_q[VA_W-1:TAG_LSB]),
        .ins_frame  (chk_frame),
        .ins_rights (rights_q & chk_rights)
    );

    xlate_permchk #(.PFN_W(PFN_W)) u_chk (
        .entry     (mem_rsp_rdata),
        .acc_write (wr_q),
        .acc_user  (us_q),
        .fault     (chk_fault),
        .rights    (chk_rights),
        .frame     (chk_frame)
    );

    // next-state selection
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (accept) nxt = (pdc_hit && pdc_deny) ? ST_RESP : ST_FETCH;
            ST_FETCH: if (mem_rsp_valid) begin
                          if (chk_fault != FLT_NONE) nxt = ST_RESP;
                          else if (lvl == 2'd0)      nxt = ST_MARK;
                      end
            ST_MARK:  if (mem_rsp_valid) nxt = ST_RESP;
            ST_RESP:  nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // walk datapath and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl         <= '0;
            va_q        <= '0;
            wr_q        <= 1'b0;
            us_q        <= 1'b0;
            frame_q     <= '0;
            rights_q    <= '0;
            leaf_q      <= '0;
            leaf_addr_q <= '0;
            res_fault   <= FLT_NONE;
            res_pfn     <= '0;
            res_paddr   <= '0;
            res_perm    <= '0;
        end else if (accept) begin
            va_q      <= req_vaddr;
            wr_q      <= req_write;
            us_q      <= req_user;
            res_fault <= (pdc_hit && pdc_deny) ? FLT_PERM : FLT_NONE;
            res_pfn   <= '0;
            res_paddr <= '0;
            res_perm  <= '0;
            if (pdc_hit) begin
                lvl      <= 2'd1;
                frame_q  <= pdc_frame;
                rights_q <= pdc_rights;
            end else begin
                lvl      <= 2'd3;
                frame_q  <= root_pfn;
                rights_q <= 2'b11;
            end
        end else if (rd_done) begin
            if (chk_fault != FLT_NONE) begin
                res_fault <= chk_fault;
            end else begin
                frame_q     <= chk_frame;
                rights_q    <= rights_q & chk_rights;
                lvl         <= lvl - 2'd1;
                leaf_q      <= mem_rsp_rdata;
                leaf_addr_q <= entry_addr;
                if (lvl == 2'd0) begin
                    res_pfn   <= chk_frame;
                    res_paddr <= {chk_frame, va_q[OFF_W-1:0]};
                    res_perm  <= rights_q & chk_rights;
                end
            end
        end
    end

    // outputs
    always_comb begin
        req_ready     = (state == ST_IDLE);
        done          = (state == ST_RESP);
        mem_req_valid = (state == ST_FETCH) || (state == ST_MARK);
        mem_req_write = (state == ST_MARK);
        mem_req_addr  = (state == ST_MARK) ? leaf_addr_q : entry_addr;
        mem_req_wdata = leaf_q | (ENTRY_W'(1) << BIT_ACCESS);
    end
endmodule

// File: rtl/xlate_walker_chk.sv
module xlate_walker_chk #(
    parameter int PA_W = 52
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_ready,
    input logic            mem_req_valid,
    input logic            mem_req_write,
    input logic [PA_W-1:0] mem_req_addr,
    input logic            mem_rsp_valid,
    input logic            done,
    input logic [1:0]      res_fault
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready); // R11

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_rsp_valid) |=> (mem_req_valid && $stable(mem_req_addr))); // R2

    AST_FAULT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (res_fault != 2'd3)); // R3

    AST_MARK_BEFORE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && res_fault == 2'd0) |-> $past(mem_req_valid && mem_req_write && mem_rsp_valid)); // R6

    AST_NO_MARK_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && res_fault != 2'd0) |-> !$past(mem_req_write)); // R6
endmodule

bind xlate_walker xlate_walker_chk #(.PA_W(PFN_W + xlate_pkg::OFF_W)) u_walker_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_ready     (req_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .done          (done),
    .res_fault     (res_fault)
);

// File: tb/xlate_walker_bench.sv
module xlate_walker_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [39:0] ROOT = 40'h100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [47:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic        mem_req_valid, mem_req_write;
    logic [51:0] mem_req_addr;
    logic [63:0] mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_rdata = '0;
    logic        done;
    logic [1:0]  res_fault;
    logic [39:0] res_pfn;
    logic [51:0] res_paddr;
    logic [1:0]  res_perm;

    always #(CLK_PERIOD / 2) clk = ~clk;

    xlate_walker u_xlate_walker (
        .clk(clk), .rst_n(rst_n), .root_pfn(ROOT),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_user(req_user),
        .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
        .done(done), .res_fault(res_fault), .res_pfn(res_pfn),
        .res_paddr(res_paddr), .res_perm(res_perm)
    );

    typedef struct {
        logic [1:0]  kind;
        logic [39:0] pfn;
        logic [51:0] paddr;
        logic [1:0]  perm;
        int          nrd;
        int          nwr;
        logic [51:0] first;
        logic [51:0] waddr;
        logic [63:0] wdata;
    } item_t;

    item_t       exp_q[$];
    string       tag_q[$];
    logic [63:0] mem [logic [51:0]];
    int          rd_cnt, wr_cnt;
    logic [51:0] first_rd, last_waddr;
    logic [63:0] last_wdata;
    int          n_tests = 0;
    int          n_fail = 0;

    localparam logic [63:0] F_P = 64'h1, F_W = 64'h2, F_U = 64'h4;
    localparam logic [63:0] F_ALL = F_P | F_W | F_U;

    function automatic logic [51:0] eaddr(logic [39:0] fr, logic [8:0] ix);
        return {fr, 12'h000} + {40'h0, ix, 3'b000};
    endfunction

    function automatic logic [63:0] rd(logic [51:0] a);
        return mem.exists(a) ? mem[a] : 64'h0;
    endfunction

    task automatic set_pte(logic [39:0] fr, logic [8:0] ix, logic [39:0] nxt, logic [63:0] fl);
        mem[eaddr(fr, ix)] = {12'h0, nxt, 12'h000} | fl;
    endtask

    function automatic logic [47:0] va(int a, int b, int c, int d, int off);
        return {9'(a), 9'(b), 9'(c), 9'(d), 12'(off)};
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // bench memory model
    initial begin
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (mem_req_valid) begin
                @(negedge clk);
                if (mem_req_write) begin
                    mem[mem_req_addr] = mem_req_wdata;
                    wr_cnt++;
                    last_waddr = mem_req_addr;
                    last_wdata = mem_req_wdata;
                end else begin
                    mem_rsp_rdata = rd(mem_req_addr);
                    if (rd_cnt == 0) first_rd = mem_req_addr;
                    rd_cnt++;
                end
                mem_rsp_valid = 1'b1;
            end
        end
    end

    // monitor: pop and compare on each result strobe
    initial begin
        forever begin
            @(negedge clk);
            if (done) begin
                if (exp_q.size() == 0) begin
                    check("R11 unexpected done", 64'd1, 64'd0);
                end else begin
                    item_t e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check({t, " fault"}, 64'(res_fault), 64'(e.kind));
                    check({t, " reads"}, 64'(rd_cnt), 64'(e.nrd));
                    check({t, " R6 writes"}, 64'(wr_cnt), 64'(e.nwr));
                    if (e.nrd > 0) check({t, " R2 first read"}, 64'(first_rd), 64'(e.first));
                    if (e.kind == 2'd0) begin
                        check({t, " R5 pfn"}, 64'(res_pfn), 64'(e.pfn));
                        check({t, " R5 paddr"}, 64'(res_paddr), 64'(e.paddr));
                        check({t, " R5 perm"}, 64'(res_perm), 64'(e.perm));
                        check({t, " R6 waddr"}, 64'(last_waddr), 64'(e.waddr));
                        check({t, " R6 wdata"}, last_wdata, e.wdata);
                    end
                    @(negedge clk);
                    check({t, " R11 done one cycle"}, 64'(done), 64'd0);
                end
            end
        end
    end

    // driver: reference walk from the requirements, then issue
    task automatic drive(logic [47:0] v, logic w, logic u, bit cached, int nrd, string t);
        item_t e;
        logic [39:0] fr;
        logic [1:0]  rt;
        logic [63:0] ent;
        logic [51:0] a;
        logic [51:0] dir_a;
        e.kind = 2'd0; e.pfn = '0; e.paddr = '0; e.perm = '0;
        e.waddr = '0; e.wdata = '0; e.nwr = 0; e.nrd = nrd;
        fr = ROOT; rt = 2'b11; dir_a = '0;
        for (int l = 3; l >= 0; l--) begin
            a = eaddr(fr, v[12 + 9*l +: 9]);
            if (l == 1) dir_a = a;
            ent = rd(a);
            if (!ent[0]) begin e.kind = 2'd1; break; end
            if ((w && !ent[1]) || (u && !ent[2])) begin e.kind = 2'd2; break; end
            rt = rt & {ent[1], ent[2]};
            fr = ent[51:12];
            if (l == 0) begin
                e.pfn = fr; e.perm = rt; e.paddr = {fr, v[11:0]};
                e.waddr = a; e.wdata = ent | 64'h20; e.nwr = 1;
            end
        end
        e.first = cached ? dir_a : eaddr(ROOT, v[47:39]);
        exp_q.push_back(e);
        tag_q.push_back(t);
        rd_cnt = 0; wr_cnt = 0; first_rd = '0;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = v; req_write = w; req_user = u;
        @(negedge clk);
        req_valid = 1'b0;
        check({t, " R11 busy"}, 64'(req_ready), 64'd0);
        wait (exp_q.size() == 0);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // region A: top 1 / second 2 / dir 3
        set_pte(ROOT, 1, 40'h200, F_ALL);
        set_pte(40'h200, 2, 40'h300, F_ALL);
        set_pte(40'h300, 3, 40'h400, F_ALL);
        set_pte(40'h400, 4, 40'h12345, F_ALL);
        set_pte(40'h400, 5, 40'h777, F_P);
        // region B: top entry lacks user
        set_pte(ROOT, 2, 40'h210, F_P | F_W);
        set_pte(40'h210, 0, 40'h310, F_ALL);
        set_pte(40'h310, 0, 40'h410, F_ALL);
        set_pte(40'h410, 0, 40'h55, F_ALL);
        // region C: top absent (no entry)
        // region D: directory entry absent
        set_pte(ROOT, 4, 40'h220, F_ALL);
        set_pte(40'h220, 0, 40'h320, F_ALL);
        // region E: three second-level slots
        set_pte(ROOT, 5, 40'h230, F_ALL);
        for (int k = 0; k < 3; k++) begin
            set_pte(40'h230, 9'(k), 40'h330 + 40'(k), F_ALL);
            set_pte(40'h330 + 40'(k), 0, 40'h430 + 40'(k), F_ALL);
            set_pte(40'h430 + 40'(k), 0, 40'h900 + 40'(k), F_ALL);
        end
        // region F: second level lacks user and write
        set_pte(ROOT, 6, 40'h240, F_ALL);
        set_pte(40'h240, 0, 40'h340, F_P);
        set_pte(40'h340, 0, 40'h440, F_ALL);
        set_pte(40'h440, 0, 40'h66, F_ALL);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready", 64'(req_ready), 64'd1);
        check("R1 done", 64'(done), 64'd0);
        check("R1 mem idle", 64'(mem_req_valid), 64'd0);

        drive(va(1, 2, 3, 4, 'habc), 1'b0, 1'b1, 1'b0, 4, "R2 R5 full walk A");
        drive(va(1, 2, 3, 4, 'h123), 1'b1, 1'b1, 1'b1, 2, "R7 hit A");
        drive(va(1, 2, 3, 5, 'h010), 1'b0, 1'b0, 1'b1, 2, "R5 hit A2 merged");
        drive(va(1, 2, 3, 5, 'h010), 1'b1, 1'b0, 1'b1, 2, "R4 leaf perm fault");
        drive(va(2, 0, 0, 0, 'h000), 1'b0, 1'b1, 1'b0, 1, "R4 top perm fault");
        drive(va(2, 0, 0, 0, 'h004), 1'b0, 1'b0, 1'b0, 4, "R10 no fill on top fault");
        drive(va(2, 0, 0, 0, 'h008), 1'b0, 1'b1, 1'b1, 0, "R8 cached deny");
        drive(va(3, 0, 0, 0, 'h000), 1'b0, 1'b0, 1'b0, 1, "R3 top absent");
        drive(va(4, 0, 0, 0, 'h000), 1'b0, 1'b0, 1'b0, 3, "R3 dir absent");
        drive(va(4, 0, 0, 0, 'h000), 1'b0, 1'b0, 1'b1, 1, "R10 filled after dir fault");
        drive(va(5, 0, 0, 0, 'h0f0), 1'b1, 1'b0, 1'b0, 4, "R9 fill E0");
        drive(va(5, 1, 0, 0, 'h0f1), 1'b1, 1'b0, 1'b0, 4, "R9 fill E1");
        drive(va(5, 2, 0, 0, 'h0f2), 1'b1, 1'b0, 1'b0, 4, "R9 fill E2");
        drive(va(1, 2, 3, 4, 'h777), 1'b0, 1'b0, 1'b0, 4, "R9 A evicted");
        drive(va(5, 2, 0, 0, 'h0f3), 1'b0, 1'b1, 1'b1, 2, "R9 E2 kept");
        drive(va(6, 0, 0, 0, 'h000), 1'b0, 1'b1, 1'b0, 2, "R4 second perm fault");
        drive(va(6, 0, 0, 0, 'h000), 1'b0, 1'b0, 1'b0, 4, "R10 no fill on second fault");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule